// File: doc/BRIEF.md
# Pin Waveform Formatter

This block shapes the drive waveform of a single tester channel over a repeating vector period. The period is a fixed number of fast-clock ticks. Each vector carries four things: the stimulus bit taken from pin memory, a shaping format, and a window given as a start tick and an end tick. The window edges set the moments at which the pin changes level. The format sets what the pin shows inside the window and what it shows for the rest of the period. The block drives two outputs, a logic level and a drive enable, so the channel can also be released to high impedance.

Vectors come in on a valid/ready stream. The block asks for a new vector only during the last tick of each period. A vector accepted on that tick governs every tick of the following period. If no vector is offered at a boundary, the previous vector is replayed, so the sender can pause without the pin going to an undefined state. Once the sender raises valid, it should keep the payload steady until ready is seen. Back-pressure lasts at most one period, because ready comes back every period.

Top module: `pin_wave_formatter`

## Requirements
- R1: `in_ready` is high exactly during the last tick of each period, once every `PERIOD_TICKS` cycles. A vector accepted when `in_valid && in_ready` governs ticks 0 to `PERIOD_TICKS-1` of the next period. The pin level for tick k is present on the outputs from the k-th clock edge after acceptance until the edge after that.
- R2: When `in_valid` is low at a boundary, the previous vector repeats unchanged. The payload inputs are ignored.
- R3: Nonreturn (format code 0) drives the stimulus bit with enable high for the whole period and ignores the window. Two zero vectors in a row therefore keep the pin low across the boundary.
- R4: Return-to-zero (code 1) drives the stimulus bit inside the window and drives 0 outside it, with enable high throughout.
- R5: Return-to-one (code 2) drives the stimulus bit inside the window and drives 1 outside it, with enable high throughout.
- R6: Return-to-high-impedance (code 3) drives the stimulus bit with enable high inside the window. Outside the window, enable is low and the level output is 0. Enable is low only in this format.
- R7: Return-to-complement (code 4) drives the stimulus bit inside the window and its inverse outside it, with enable high throughout.
- R8: Tick t lies in the window when start ≤ t < end, so an end of `PERIOD_TICKS` reaches the last tick. When start ≥ end, the window is empty and a return format shows its return value for the whole period. Nonreturn is not affected by this.
- R9: Format codes 5, 6 and 7 behave as nonreturn.
- R10: After reset, the tick count is 0, `drv_en` and `drv_val` are 0, and the held vector is return-to-high-impedance with an empty window. The pin therefore stays released until the first accepted vector takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Vector offered |
| in_ready | output | 1 | Vector taken this cycle (last tick of period) |
| in_data | input | 1 | Stimulus bit from pin memory |
| in_fmt | input | 3 | Shaping format code |
| in_start | input | TW | First tick inside the window |
| in_end | input | TW | First tick after the window |
| drv_val | output | 1 | Pin drive level |
| drv_en | output | 1 | Pin drive enable (0 = high impedance) |

## Verification
`in_ready` is decoded from the tick register, so it is valid for the whole last tick. The bench therefore reads it in the same cycle it offers a vector. The output flops are loaded from the next-state tick and vector, so the level for tick k appears right after the k-th edge following acceptance, with no added pipeline delay. After the accepting edge, the bench samples both outputs and `in_ready` 1 ns past every edge, for each of the period's ticks. Each sample is compared with the tick-by-tick value computed from the format rules, so an edge that moves by even one tick is caught.

// File: rtl/wf_pkg.sv
package wf_pkg;

  localparam int FMT_W = 3;

  typedef enum logic [FMT_W-1:0] {
    FMT_NONRET = 3'd0,
    FMT_RZ     = 3'd1,
    FMT_RO     = 3'd2,
    FMT_RHZ    = 3'd3,
    FMT_RC     = 3'd4
  } wf_fmt_e;

endpackage

// File: rtl/wf_tick_counter.sv
module wf_tick_counter #(
  parameter int PERIOD_TICKS = 50,
  parameter int TW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick_q,
  output logic [TW-1:0] tick_d,
  output logic          last_q
);

  localparam logic [TW-1:0] LAST_TICK = TW'(PERIOD_TICKS - 1);

  assign last_q = (tick_q == LAST_TICK);

  always_comb begin
    if (last_q) tick_d = '0;
    else        tick_d = tick_q + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

endmodule

// File: rtl/wf_vector_reg.sv
module wf_vector_reg
  import wf_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             new_data,
  input  logic [FMT_W-1:0] new_fmt,
  input  logic [TW-1:0]    new_start,
  input  logic [TW-1:0]    new_end,
  output logic             cur_data,
  output logic [FMT_W-1:0] cur_fmt,
  output logic [TW-1:0]    cur_start,
  output logic [TW-1:0]    cur_end,
  output logic             nxt_data,
  output logic [FMT_W-1:0] nxt_fmt,
  output logic [TW-1:0]    nxt_start,
  output logic [TW-1:0]    nxt_end
);

  // Next-state view lets the output stage shape the coming tick in advance.
  always_comb begin
    if (load) begin
      nxt_data  = new_data;
      nxt_fmt   = new_fmt;
      nxt_start = new_start;
      nxt_end   = new_end;
    end else begin
      nxt_data  = cur_data;
      nxt_fmt   = cur_fmt;
      nxt_start = cur_start;
      nxt_end   = cur_end;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_data  <= 1'b0;
      cur_fmt   <= FMT_RHZ;
      cur_start <= '0;
      cur_end   <= '0;
    end else begin
      cur_data  <= nxt_data;
      cur_fmt   <= nxt_fmt;
      cur_start <= nxt_start;
      cur_end   <= nxt_end;
    end
  end

endmodule

// File: rtl/wf_shaper.sv
module wf_shaper
  import wf_pkg::*;
#(
  parameter int TW = 6
) (
  input  logic [TW-1:0]    tick,
  input  logic             data,
  input  logic [FMT_W-1:0] fmt,
  input  logic [TW-1:0]    win_start,
  input  logic [TW-1:0]    win_end,
  output logic             pin_val,
  output logic             pin_en
);

  logic    in_window;
  logic    use_window;
  logic    ret_val;
  logic    ret_en;
  wf_fmt_e fmt_e;

  assign in_window = (tick >= win_start) && (tick < win_end);

  always_comb begin
    fmt_e      = wf_fmt_e'(fmt);
    use_window = 1'b1;
    ret_val    = data;
    ret_en     = 1'b1;
    case (fmt_e)
      FMT_RZ:  ret_val = 1'b0;
      FMT_RO:  ret_val = 1'b1;
      FMT_RHZ: begin
        ret_val = 1'b0;
        ret_en  = 1'b0;
      end
      FMT_RC:  ret_val = ~data;
      default: use_window = 1'b0;
    endcase
  end

  always_comb begin
    if (!use_window || in_window) begin
      pin_val = data;
      pin_en  = 1'b1;
    end else begin
      pin_val = ret_val;
      pin_en  = ret_en;
    end
  end

endmodule

// File: rtl/pin_wave_formatter.sv
module pin_wave_formatter
  import wf_pkg::*;
#(
  parameter int PERIOD_TICKS = 50,
  localparam int TW = $clog2(PERIOD_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_data,
  input  logic [FMT_W-1:0] in_fmt,
  input  logic [TW-1:0]    in_start,
  input  logic [TW-1:0]    in_end,
  output logic             drv_val,
  output logic             drv_en
);

  logic [TW-1:0]    tick_q;
  logic [TW-1:0]    tick_d;
  logic             last_tick;
  logic             take;

  logic             act_data;
  logic [FMT_W-1:0] act_fmt;
  logic [TW-1:0]    act_start;
  logic [TW-1:0]    act_end;
  logic             nxt_data;
  logic [FMT_W-1:0] nxt_fmt;
  logic [TW-1:0]    nxt_start;
  logic [TW-1:0]    nxt_end;

  logic             shp_val;
  logic             shp_en;

  wf_tick_counter #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .TW          (TW)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick_q(tick_q),
    .tick_d(tick_d),
    .last_q(last_tick)
  );

  assign in_ready = last_tick;
  assign take     = in_valid && last_tick;

  wf_vector_reg #(
    .TW(TW)
  ) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .new_data (in_data),
    .new_fmt  (in_fmt),
    .new_start(in_start),
    .new_end  (in_end),
    .cur_data (act_data),
    .cur_fmt  (act_fmt),
    .cur_start(act_start),
    .cur_end  (act_end),
    .nxt_data (nxt_data),
    .nxt_fmt  (nxt_fmt),
    .nxt_start(nxt_start),
    .nxt_end  (nxt_end)
  );

  // Shape the tick about to start so the pin level leaves a flop.
  wf_shaper #(
    .TW(TW)
  ) u_shape (
    .tick     (tick_d),
    .data     (nxt_data),
    .fmt      (nxt_fmt),
    .win_start(nxt_start),
    .win_end  (nxt_end),
    .pin_val  (shp_val),
    .pin_en   (shp_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_val <= 1'b0;
      drv_en  <= 1'b0;
    end else begin
      drv_val <= shp_val;
      drv_en  <= shp_en;
    end
  end

endmodule

// File: rtl/wf_checker.sv
module wf_checker #(
  parameter int PERIOD_TICKS = 50,
  localparam int TW = $clog2(PERIOD_TICKS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_data,
  input logic [2:0]    in_fmt,
  input logic          drv_val,
  input logic          drv_en,
  input logic          act_data,
  input logic [2:0]    act_fmt,
  input logic [TW-1:0] act_start,
  input logic [TW-1:0] act_end
);

  localparam logic [TW-1:0] LAST = TW'(PERIOD_TICKS - 1);

  logic [TW-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              gap_cnt <= '0;
    else if (gap_cnt == LAST) gap_cnt <= '0;
    else                     gap_cnt <= gap_cnt + TW'(1);
  end

  AST_READY_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (gap_cnt == LAST)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(act_fmt) && $stable(act_data) &&
                                 $stable(act_start) && $stable(act_end))); // R2

  AST_NONRET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_fmt == 3'd0) |=> (drv_en && drv_val == $past(in_data))); // R3

  AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !drv_val); // R6

  AST_RELEASE_ONLY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> act_fmt == 3'd3); // R6

  AST_EMPTY_RZ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fmt == 3'd1 && act_start >= act_end) |-> (drv_en && !drv_val)); // R8

  AST_EMPTY_RO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fmt == 3'd2 && act_start >= act_end) |-> (drv_en && drv_val)); // R8

endmodule

bind pin_wave_formatter wf_checker #(
  .PERIOD_TICKS(PERIOD_TICKS)
) u_wf_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .in_fmt   (in_fmt),
  .drv_val  (drv_val),
  .drv_en   (drv_en),
  .act_data (act_data),
  .act_fmt  (act_fmt),
  .act_start(act_start),
  .act_end  (act_end)
);

// File: tb/pin_wave_formatter_tb.sv
module pin_wave_formatter_tb;

  localparam int P  = 50;
  localparam int TW = $clog2(P + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_data = 1'b0;
  logic [2:0]    in_fmt = 3'd0;
  logic [TW-1:0] in_start = '0;
  logic [TW-1:0] in_end = '0;
  logic          drv_val;
  logic          drv_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model of the vector currently in force
  logic       m_data = 1'b0;
  logic [2:0] m_fmt = 3'd3;
  int         m_start = 0;
  int         m_end = 0;

  always #10 clk = ~clk;

  pin_wave_formatter #(.PERIOD_TICKS(P)) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .in_data (in_data),
    .in_fmt  (in_fmt),
    .in_start(in_start),
    .in_end  (in_end),
    .drv_val (drv_val),
    .drv_en  (drv_en)
  );

  function automatic logic [1:0] pin_model(logic d, logic [2:0] f, int s, int e, int k);
    bit win;
    win = (f == 3'd0 || f > 3'd4) ? 1'b1 : (k >= s && k < e);
    if (win) return {1'b1, d};
    case (f)
      3'd1:    return {1'b1, 1'b0};
      3'd2:    return {1'b1, 1'b1};
      3'd3:    return {1'b0, 1'b0};
      default: return {1'b1, ~d};
    endcase
  endfunction

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    int n;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R10", "reset {en,val}", {drv_en, drv_val}, 2'b00);
    check("R10", "reset ready", {1'b0, in_ready}, 2'b00);
    n = 0;
    while (!in_ready && n < 2 * P) begin
      @(negedge clk);
      if (!in_ready) check("R10", "released before first vector", {drv_en, drv_val}, 2'b00);
      n++;
    end
    check("R1", "edges until first ready", 2'(n == P - 1), 2'b01);
  endtask

  // offer (or withhold) a vector, then check every tick of the period it governs
  task automatic run_vec(string tag, bit offer, logic d, logic [2:0] f, int s, int e);
    if (offer) begin
      in_valid = 1'b1;
      in_data  = d;
      in_fmt   = f;
      in_start = TW'(s);
      in_end   = TW'(e);
      m_data = d; m_fmt = f; m_start = s; m_end = e;
    end else begin
      in_valid = 1'b0;
      in_data  = ~m_data;
      in_fmt   = 3'd4 - m_fmt[1:0];
      in_start = TW'(3);
      in_end   = TW'(7);
    end
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    for (int k = 0; k < P; k++) begin
      check(tag, $sformatf("tick %0d {en,val}", k), {drv_en, drv_val},
            pin_model(m_data, m_fmt, m_start, m_end, k));
      check("R1", $sformatf("ready at tick %0d", k), {1'b0, in_ready}, {1'b0, 1'(k == P - 1)});
      if (k < P - 1) begin
        @(posedge clk);
        #1;
      end
    end
  endtask

  initial begin
    do_reset();
    run_vec("R3 nonreturn one",     1'b1, 1'b1, 3'd0, 25, 30);
    run_vec("R3 nonreturn zero a",  1'b1, 1'b0, 3'd0, 25, 30);
    run_vec("R3 nonreturn zero b",  1'b1, 1'b0, 3'd0, 15, 30);
    run_vec("R4 return-zero",       1'b1, 1'b1, 3'd1, 25, 30);
    run_vec("R5 return-one",        1'b1, 1'b0, 3'd2, 15, 30);
    run_vec("R6 return-hiz",        1'b1, 1'b1, 3'd3, 15, 30);
    run_vec("R2 idle repeats",      1'b0, 1'b0, 3'd0, 0, 0);
    run_vec("R7 complement one",    1'b1, 1'b1, 3'd4, 25, 30);
    run_vec("R7 complement zero",   1'b1, 1'b0, 3'd4, 0, 5);
    run_vec("R8 window to end",     1'b1, 1'b0, 3'd4, 0, P);
    run_vec("R8 empty rz",          1'b1, 1'b1, 3'd1, 30, 25);
    run_vec("R8 empty ro",          1'b1, 1'b0, 3'd2, 10, 10);
    run_vec("R8 empty hiz",         1'b1, 1'b1, 3'd3, 40, 2);
    run_vec("R8 nonreturn ignores", 1'b1, 1'b1, 3'd0, 40, 5);
    run_vec("R9 code 6",            1'b1, 1'b1, 3'd6, 20, 30);
    run_vec("R9 code 7",            1'b1, 1'b0, 3'd7, 20, 30);
    run_vec("R9 code 5",            1'b1, 1'b1, 3'd5, 45, 10);
    run_vec("R2 idle after code",   1'b0, 1'b0, 3'd0, 0, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule